// File: doc/BRIEF.md
# NAND Flash Host Interface Front End

This block connects a simple register bus to an 8- or 16-bit NAND flash device. Software queues command, address and data-write operations by writing to dedicated registers. Each write becomes an entry in a four-deep ordered buffer. A strobe engine drains the buffer one entry at a time and drives the matching latch cycle on the device pins. The widths of the read and write strobes are programmed in system clock cycles.

A single read takes two steps. Software first writes any value to a read-request register, which queues a read cycle behind any operations already waiting. Software then collects the captured word from a read-data register once a sticky read-ready interrupt bit has set. That bit is cleared by writing one to it.

The same status register also reports the device's ready/busy pin. Unmasked status bits raise an interrupt output. Two further registers produce one-cycle start pulses. The first starts a page-streaming path. The second clears the ECC accumulators, which must be done before every page.

Top module: `nfc_host`

## Requirements
- R1: After reset the chip enable and both strobes are inactive (high), CLE and ALE are low, the interrupt output is low, the mask register (offset 3) reads 2'b11, and the status register (offset 1) reads 2 (bit 1 idle set, bit 0 full clear).
- R2: A write to offset 4 produces exactly one write-strobe cycle with CLE high and ALE low, driving the low byte of the written value with the upper 8 bits of the device bus zero.
- R3: A write to offset 5 produces one write-strobe cycle with ALE high and CLE low, driving the low byte of the value.
- R4: The control register (offset 0) holds the write delay in bits 3:0 and the read delay in bits 7:4. A write strobe stays low for write delay plus one cycles, and a read strobe stays low for read delay plus one cycles.
- R5: The buffer holds four entries and drains them in the order written. Status bit 0 is set while it is full, and a command, address, data or read-request write that arrives while it is full is discarded.
- R6: Control bit 8 selects the bus width. When it is 1, data writes (offset 6) drive all 16 bits and reads capture all 16 bits. When it is 0, only the low 8 bits are driven or captured and the upper 8 bits are zero.
- R7: A write of any value to offset 7 queues a read cycle. When that cycle ends, the captured word appears at offset 8 and interrupt status bit 1 (offset 2) sets. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: Interrupt status bit 0 follows the device ready/busy input (1 = ready) with one register stage of delay.
- R9: The interrupt output is high whenever an interrupt status bit is set and the same bit of the mask register is 0.
- R10: The chip enable is low from the cycle after the first operation is queued until the buffer is empty and the strobe engine is idle. It is low during every strobe.
- R11: Writing 1 to offset 10 gives a one-cycle page-read start pulse, and writing 2 gives a one-cycle page-write start pulse. Any other value gives neither. The page length output reads 512 when control bit 9 is 1 and 256 when it is 0.
- R12: A write to offset 9 with bit 0 set gives a one-cycle ECC-clear pulse. A write with bit 0 clear gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Register write offset |
| bus_wdata | input | 16 | Register write data |
| bus_raddr | input | 4 | Register read offset |
| bus_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 16 | Data returned by the device |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |
| page_rd_go | output | 1 | Page-read start pulse |
| page_wr_go | output | 1 | Page-write start pulse |
| page_bytes | output | 10 | Selected page length in bytes |
| ecc_clr | output | 1 | ECC accumulator clear pulse |

## Verification
Several internal faults show up directly at the pins. A corrupted buffer pointer or count shows as a missing, duplicated or reordered latch cycle, or as a full flag that does not match the number of queued writes. The next drained entry exposes it, within one entry period of the write delay plus three cycles. A wrong delay counter shows in the measured low width of the very next strobe. A stuck read-ready bit or a wrong width fold shows at the next collection of the read-data register.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DLY_W  = 4;
  localparam int CTRL_W = 10;
  localparam int PGB_W  = 10;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_ADDR  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_DWR   = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_DRQ   = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_RDAT  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_ECCR  = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_PGC   = 4'd10;

  // control field positions (decoded by the strobe engine and page logic)
  localparam int CF_WDLY = 0;
  localparam int CF_RDLY = 4;
  localparam int CF_WIDE = 8;
  localparam int CF_PG   = 9;

  typedef enum logic [1:0] {K_CMD, K_ADR, K_DAT, K_RD} op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [BUS_W-1:0]  val;
  } wb_entry_t;

  // keep the low byte only unless the 16-bit bus is selected
  function automatic logic [BUS_W-1:0] fold_bus(input logic [BUS_W-1:0] v,
                                                input logic wide);
    return wide ? v : {{(BUS_W-8){1'b0}}, v[7:0]};
  endfunction

  function automatic logic [PGB_W-1:0] page_len(input logic big);
    return big ? PGB_W'(512) : PGB_W'(256);
  endfunction
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t din,
  input  logic      pop,
  output wb_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wb_entry_t        mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              avail,
  input  wb_entry_t         head,
  input  logic              wide,
  input  logic [DLY_W-1:0]  wr_dly,
  input  logic [DLY_W-1:0]  rd_dly,
  input  logic [BUS_W-1:0]  dq_in,
  output logic              pop,
  output logic              busy,
  output logic              we_n,
  output logic              re_n,
  output logic              cle,
  output logic              ale,
  output logic [BUS_W-1:0]  dq_out,
  output logic              dq_oe,
  output logic              rd_done,
  output logic [BUS_W-1:0]  rd_val
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HOLD} st_e;

  st_e              st;
  wb_entry_t        cur;
  logic [DLY_W-1:0] cnt;
  logic             is_rd;
  logic             active;

  assign is_rd  = (cur.kind == K_RD);
  assign active = (st != S_IDLE);
  assign pop    = (st == S_IDLE) && avail;
  assign busy   = active;

  assign we_n    = !((st == S_LOW) && !is_rd);
  assign re_n    = !((st == S_LOW) && is_rd);
  assign cle     = active && (cur.kind == K_CMD);
  assign ale     = active && (cur.kind == K_ADR);
  assign dq_oe   = active && !is_rd;
  assign dq_out  = dq_oe ? fold_bus(cur.val, wide && (cur.kind == K_DAT)) : '0;
  assign rd_done = (st == S_HOLD) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= '{kind: K_CMD, val: '0};
      cnt    <= '0;
      rd_val <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (avail) begin
            cur <= head;
            cnt <= (head.kind == K_RD) ? rd_dly : wr_dly;
            st  <= S_LOW;
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            st <= S_HOLD;
            if (is_rd) rd_val <= fold_bus(dq_in, wide);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              wb_full,
  input  logic              wb_empty,
  input  logic              eng_busy,
  input  logic              rd_done,
  input  logic [BUS_W-1:0]  rd_val,
  input  logic              nand_rb,
  output logic              push,
  output wb_entry_t         push_entry,
  output logic              wide,
  output logic [DLY_W-1:0]  wr_dly,
  output logic [DLY_W-1:0]  rd_dly,
  output logic [PGB_W-1:0]  page_bytes,
  output logic              irq,
  output logic              rd_ready,
  output logic              page_rd_go,
  output logic              page_wr_go,
  output logic              ecc_clr
);
  logic [CTRL_W-1:0] ctrl;
  logic [1:0]        imask;
  logic              nbusy;
  logic [BUS_W-1:0]  rdata;
  logic              is_q;
  logic              w1c_rdy;

  assign wr_dly     = ctrl[CF_WDLY +: DLY_W];
  assign rd_dly     = ctrl[CF_RDLY +: DLY_W];
  assign wide       = ctrl[CF_WIDE];
  assign page_bytes = page_len(ctrl[CF_PG]);

  always_comb begin
    is_q            = 1'b1;
    push_entry.val  = bus_wdata;
    case (bus_waddr)
      OFS_CMD:  push_entry.kind = K_CMD;
      OFS_ADDR: push_entry.kind = K_ADR;
      OFS_DWR:  push_entry.kind = K_DAT;
      OFS_DRQ:  push_entry.kind = K_RD;
      default: begin
        push_entry.kind = K_CMD;
        is_q            = 1'b0;
      end
    endcase
  end

  assign push    = bus_wr && is_q && !wb_full;
  assign w1c_rdy = bus_wr && (bus_waddr == OFS_ISTAT) && bus_wdata[1];
  assign irq     = |({rd_ready, nbusy} & ~imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      imask      <= 2'b11;
      nbusy      <= 1'b0;
      rd_ready   <= 1'b0;
      rdata      <= '0;
      page_rd_go <= 1'b0;
      page_wr_go <= 1'b0;
      ecc_clr    <= 1'b0;
    end else begin
      nbusy      <= nand_rb;
      page_rd_go <= bus_wr && (bus_waddr == OFS_PGC) && (bus_wdata == BUS_W'(1));
      page_wr_go <= bus_wr && (bus_waddr == OFS_PGC) && (bus_wdata == BUS_W'(2));
      ecc_clr    <= bus_wr && (bus_waddr == OFS_ECCR) && bus_wdata[0];
      if (bus_wr && bus_waddr == OFS_CTRL)  ctrl  <= bus_wdata[CTRL_W-1:0];
      if (bus_wr && bus_waddr == OFS_IMASK) imask <= bus_wdata[1:0];
      if (rd_done) begin
        rd_ready <= 1'b1;
        rdata    <= rd_val;
      end else if (w1c_rdy) begin
        rd_ready <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_raddr)
      OFS_CTRL:  bus_rdata = BUS_W'(ctrl);
      OFS_STAT:  bus_rdata = BUS_W'({wb_empty && !eng_busy, wb_full});
      OFS_ISTAT: bus_rdata = BUS_W'({rd_ready, nbusy});
      OFS_IMASK: bus_rdata = BUS_W'(imask);
      OFS_RDAT:  bus_rdata = rdata;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_host.sv
module nfc_host
  import nfc_pkg::*;
#(
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_waddr,
  input  logic [15:0]       bus_wdata,
  input  logic [3:0]        bus_raddr,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [15:0]       nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [15:0]       nand_dq_in,
  input  logic              nand_rb,
  output logic              page_rd_go,
  output logic              page_wr_go,
  output logic [9:0]        page_bytes,
  output logic              ecc_clr
);
  wb_entry_t         push_entry, head;
  logic              push, wb_pop, wb_full, wb_empty;
  logic              eng_busy, rd_done, rd_ready, wide;
  logic [DLY_W-1:0]  wr_dly, rd_dly;
  logic [BUS_W-1:0]  rd_val;

  nfc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_waddr  (bus_waddr),
    .bus_wdata  (bus_wdata),
    .bus_raddr  (bus_raddr),
    .bus_rdata  (bus_rdata),
    .wb_full    (wb_full),
    .wb_empty   (wb_empty),
    .eng_busy   (eng_busy),
    .rd_done    (rd_done),
    .rd_val     (rd_val),
    .nand_rb    (nand_rb),
    .push       (push),
    .push_entry (push_entry),
    .wide       (wide),
    .wr_dly     (wr_dly),
    .rd_dly     (rd_dly),
    .page_bytes (page_bytes),
    .irq        (irq),
    .rd_ready   (rd_ready),
    .page_rd_go (page_rd_go),
    .page_wr_go (page_wr_go),
    .ecc_clr    (ecc_clr)
  );

  nfc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_entry),
    .pop   (wb_pop),
    .head  (head),
    .full  (wb_full),
    .empty (wb_empty)
  );

  nfc_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail   (!wb_empty),
    .head    (head),
    .wide    (wide),
    .wr_dly  (wr_dly),
    .rd_dly  (rd_dly),
    .dq_in   (nand_dq_in),
    .pop     (wb_pop),
    .busy    (eng_busy),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .dq_out  (nand_dq_out),
    .dq_oe   (nand_dq_oe),
    .rd_done (rd_done),
    .rd_val  (rd_val)
  );

  assign nand_ce_n = wb_empty && !eng_busy;
endmodule

// File: rtl/nfc_host_chk.sv
module nfc_host_chk (
  input logic clk,
  input logic rst_n,
  input logic nand_ce_n,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic wb_full,
  input logic wb_pop,
  input logic rd_done,
  input logic rd_ready,
  input logic page_rd_go,
  input logic page_wr_go
);
  // R2
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R10
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_full && !wb_pop) |=> wb_full);

  // R7
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rd_ready);

  // R11
  pg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_rd_go, page_wr_go}));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
endmodule

bind nfc_host nfc_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_ce_n  (nand_ce_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .wb_full    (wb_full),
  .wb_pop     (wb_pop),
  .rd_done    (rd_done),
  .rd_ready   (rd_ready),
  .page_rd_go (page_rd_go),
  .page_wr_go (page_wr_go)
);

// File: tb/tb_nfc_host.sv
module tb_nfc_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [3:0]  bus_raddr = '0;
  logic [15:0] bus_rdata;
  logic        irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [15:0] nand_dq_out;
  logic        nand_dq_oe;
  logic [15:0] nand_dq_in = '0;
  logic        nand_rb = 1'b1;
  logic        page_rd_go, page_wr_go, ecc_clr;
  logic [9:0]  page_bytes;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  nfc_host dut (.*);

  // strobe monitor, sampled on the falling edge
  int          wlen [64];
  logic [17:0] wcap [64];
  int          wn = 0, wcur = 0, rlen = 0, rcur = 0;
  logic [17:0] wlast;
  int          pg_rd_n = 0, pg_wr_n = 0, ecc_n = 0, ce_err = 0;

  always @(negedge clk) begin
    if (!nand_we_n) begin
      wcur++;
      wlast = {nand_cle, nand_ale, nand_dq_out};
    end else if (wcur != 0) begin
      if (wn < 64) begin
        wlen[wn] = wcur;
        wcap[wn] = wlast;
      end
      wn++;
      wcur = 0;
    end
    if (!nand_re_n) rcur++;
    else if (rcur != 0) begin
      rlen = rcur;
      rcur = 0;
    end
    if ((!nand_we_n || !nand_re_n) && nand_ce_n) ce_err++;
    if (page_rd_go) pg_rd_n++;
    if (page_wr_go) pg_wr_n++;
    if (ecc_clr) ecc_n++;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      reg_read(4'd1, s);
      if (s[1]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 ce_n", nand_ce_n, 1);
    check("R1 strobes", {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    check("R1 irq", irq, 0);
    reg_read(4'd3, d); check("R1 mask", d, 16'h3);
    reg_read(4'd1, d); check("R1 status", d, 16'h2);
  endtask

  task automatic t_cmd_addr();
    reg_write(4'd0, 16'h0002);
    wn = 0;
    reg_write(4'd4, 16'h01A5);
    reg_write(4'd5, 16'h0033);
    wait_idle();
    check("R2 count", wn, 2);
    check("R2 cmd cycle", wcap[0], {2'b10, 16'h00A5});
    check("R4 write width", wlen[0], 3);
    check("R3 addr cycle", wcap[1], {2'b01, 16'h0033});
    check("R10 ce idle", nand_ce_n, 1);
  endtask

  task automatic t_width();
    reg_write(4'd0, 16'h0130);
    wn = 0;
    reg_write(4'd6, 16'hBEEF);
    wait_idle();
    check("R6 wide data", wcap[0], {2'b00, 16'hBEEF});
    check("R4 zero delay", wlen[0], 1);
    reg_write(4'd0, 16'h0030);
    wn = 0;
    reg_write(4'd6, 16'hBEEF);
    wait_idle();
    check("R6 narrow data", wcap[0], {2'b00, 16'h00EF});
  endtask

  task automatic t_read();
    logic [15:0] d;
    nand_dq_in = 16'h5A3C;
    reg_write(4'd0, 16'h0130);
    reg_write(4'd7, 16'h0000);
    wait_idle();
    check("R4 read width", rlen, 4);
    reg_read(4'd2, d); check("R7 ready set", d[1], 1);
    reg_read(4'd8, d); check("R7 wide data", d, 16'h5A3C);
    reg_write(4'd2, 16'h0000);
    reg_read(4'd2, d); check("R7 w0 ignored", d[1], 1);
    reg_write(4'd2, 16'h0002);
    reg_read(4'd2, d); check("R7 w1c", d[1], 0);
    reg_write(4'd0, 16'h0030);
    reg_write(4'd7, 16'hFFFF);
    wait_idle();
    reg_read(4'd8, d); check("R6 narrow read", d, 16'h003C);
    reg_write(4'd2, 16'h0002);
  endtask

  task automatic t_fifo();
    logic [15:0] d;
    reg_write(4'd0, 16'h010F);
    wn = 0;
    for (int i = 1; i <= 6; i++) reg_write(4'd6, 16'h1111 * i[15:0]);
    reg_read(4'd1, d); check("R5 full flag", d, 16'h0001);
    check("R10 ce busy", nand_ce_n, 0);
    wait_idle();
    check("R5 drained", wn, 5);
    for (int i = 0; i < 5; i++)
      check("R5 order", wcap[i], {2'b00, 16'h1111 * 16'(i + 1)});
    check("R4 max width", wlen[4], 16);
    reg_read(4'd1, d); check("R5 empty", d, 16'h0002);
    check("R10 ce released", nand_ce_n, 1);
  endtask

  task automatic t_irq();
    reg_write(4'd3, 16'h0003);
    repeat (2) @(negedge clk);
    check("R9 masked", irq, 0);
    reg_write(4'd3, 16'h0002);
    #1 check("R9 nbusy irq", irq, 1);
    nand_rb = 1'b0;
    repeat (2) @(negedge clk);
    begin
      logic [15:0] d;
      reg_read(4'd2, d); check("R8 busy", d[0], 0);
    end
    check("R9 no irq", irq, 0);
    nand_rb = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 ready", irq, 1);
    reg_write(4'd3, 16'h0001);
    #1 check("R9 rdy masked clear", irq, 0);
    reg_write(4'd7, 16'h0000);
    wait_idle();
    check("R9 rdy irq", irq, 1);
    reg_write(4'd2, 16'h0002);
    #1 check("R9 cleared", irq, 0);
    reg_write(4'd3, 16'h0003);
  endtask

  task automatic t_page();
    pg_rd_n = 0; pg_wr_n = 0; ecc_n = 0;
    reg_write(4'd10, 16'h0001);
    reg_write(4'd10, 16'h0002);
    reg_write(4'd10, 16'h0003);
    reg_write(4'd10, 16'h0000);
    repeat (2) @(negedge clk);
    check("R11 read start", pg_rd_n, 1);
    check("R11 write start", pg_wr_n, 1);
    reg_write(4'd9, 16'h0001);
    reg_write(4'd9, 16'h0000);
    repeat (2) @(negedge clk);
    check("R12 ecc clear", ecc_n, 1);
    reg_write(4'd0, 16'h0200);
    check("R11 page 512", page_bytes, 512);
    reg_write(4'd0, 16'h0000);
    check("R11 page 256", page_bytes, 256);
    check("R10 no strobe without ce", ce_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cmd_addr();
    t_width();
    t_read();
    t_fifo();
    t_irq();
    t_page();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule